// File: doc/BRIEF.md
# Levels-Back Constrained Gene Mutator

This block walks once over the genome of a fixed-geometry feed-forward logic array and overwrites a random subset of its genes with fresh random values. The genome holds three genes per cell, cells numbered column by column, followed by one gene per array output. The first two genes of a cell name its data sources. The third is either a node number, meaning a multiplexer select, or a negative code from -1 to -12, meaning a two-input gate. Every value written lies inside the legal window for that gene's column, so the mutated genome still describes a loop-free netlist.

A run begins when `start` is seen while the block is idle. One gene is visited per clock. A xorshift random word per gene decides whether the gene is mutated and supplies the new value. A mutated gene appears as a single write on the write port, and `done` pulses as the last gene is reported. The genome is never read, because a mutation replaces the old value whole.

Top module: `lb_gene_mutator`

## Requirements
- R1: After reset, `busy`, `done` and `wr_en` are all 0.
- R2: `start` sampled high while `busy` is 0 loads the random state from `seed`, or with 1 when `seed` is 0, and sets `busy` from the next cycle. `start` is ignored while `busy` is 1, so holding it high gives exactly one `done` pulse per run.
- R3: The random state advances once per visited gene with x ^= x<<13, x ^= x>>17, x ^= x<<5 on 32 bits. Gene k (0-based) uses the word reached after k+1 steps from the loaded state.
- R4: A gene is written only when bits [RATE_W-1:0] of its word, read unsigned, are below `rate`. With `rate` = 0 there are no writes.
- R5: Genes are visited in address order 0 to NGENE-1, where NGENE = 3·ROWS·COLS + NOUT. Address k < 3·ROWS·COLS is role k mod 3 of cell k/3, and that cell is in column (k/3)/ROWS. Roles 0 and 1 are sources and role 2 is the function gene. Addresses from 3·ROWS·COLS upward are output genes.
- R6: For column c, hi(c) = c·ROWS + 2·NIN + 1 and lo(c) = 0 when c ≤ LBACK. The source-gene value is lo + ((word>>16)·S >> 16), where S = hi − lo + 1.
- R7: For c > LBACK, lo(c) = 2·NIN + 2 + (c − LBACK)·ROWS, so constants, inputs and columns further back cannot be reached.
- R8: A function gene draws idx = (word>>16)·(S+12) >> 16. The value is lo + idx when idx < S, and −(idx − S + 1) otherwise, in GENE_W-bit two's complement, giving the codes −1 to −12.
- R9: Output genes use the source-gene rule with c = COLS.
- R10: `done` is a one-cycle pulse that follows the visit of gene NGENE-1 after exactly NGENE visits, and `busy` is 0 while it is high.
- R11: The write for gene k (`wr_en`, `wr_addr` = k, `wr_data`) appears in the cycle after that gene's visit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| seed | input | 32 | Random state loaded at start |
| rate | input | RATE_W | Mutation threshold, out of 2^RATE_W |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| wr_en | output | 1 | Gene write strobe |
| wr_addr | output | AW | Gene address written |
| wr_data | output | GENE_W | New gene value, two's complement |

## Verification
With `start` sampled at edge E0, gene k is visited during the cycle that ends at edge E(k+1), and its write, along with `done` for the last gene, is visible after that edge. The bench model advances at each rising edge from the inputs driven on the previous falling edge. On the following falling edge the model's `busy`, `done` and write fields are compared against the ports, so every compare sits one edge after the cause. Each write is also checked on its own against the legal window for its role and column, which does not depend on the draw formula.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

  typedef enum logic [1:0] {
    ROLE_SRC_A = 2'd0,
    ROLE_SRC_B = 2'd1,
    ROLE_FUNC  = 2'd2,
    ROLE_OUT   = 2'd3
  } gene_role_e;

  function automatic logic [31:0] xs32_step(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

endpackage

// File: rtl/lbm_rng.sv
module lbm_rng
  import lbm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] seed,
  input  logic        step,
  output logic [31:0] word
);
  logic [31:0] state_q, state_d;

  assign word = xs32_step(state_q);

  always_comb begin
    state_d = state_q;
    if (load)      state_d = (seed == 32'd0) ? 32'd1 : seed;
    else if (step) state_d = word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= 32'd1;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/lbm_walker.sv
module lbm_walker
  import lbm_pkg::*;
#(
  parameter int ROWS  = 3,
  parameter int COLS  = 4,
  parameter int NGENE = 38,
  parameter int AW    = 6,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [AW-1:0] idx,
  output gene_role_e    role,
  output logic [CW-1:0] col,
  output logic          last
);
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic          busy_q, busy_d;
  logic [AW-1:0] idx_q, idx_d;
  logic [1:0]    sub_q, sub_d;
  logic [RW-1:0] row_q, row_d;
  logic [CW-1:0] col_q, col_d;

  assign busy = busy_q;
  assign idx  = idx_q;
  assign col  = col_q;
  assign last = (idx_q == AW'(NGENE - 1));

  always_comb begin
    if (col_q == CW'(COLS))  role = ROLE_OUT;
    else if (sub_q == 2'd2)  role = ROLE_FUNC;
    else if (sub_q == 2'd1)  role = ROLE_SRC_B;
    else                     role = ROLE_SRC_A;
  end

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    sub_d  = sub_q;
    row_d  = row_q;
    col_d  = col_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        idx_d  = '0;
        sub_d  = 2'd0;
        row_d  = '0;
        col_d  = '0;
      end
    end else if (last) begin
      busy_d = 1'b0;
    end else begin
      idx_d = idx_q + AW'(1);
      if (col_q != CW'(COLS)) begin
        if (sub_q == 2'd2) begin
          sub_d = 2'd0;
          if (row_q == RW'(ROWS - 1)) begin
            row_d = '0;
            col_d = col_q + CW'(1);
          end else begin
            row_d = row_q + RW'(1);
          end
        end else begin
          sub_d = sub_q + 2'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      sub_q  <= 2'd0;
      row_q  <= '0;
      col_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      sub_q  <= sub_d;
      row_q  <= row_d;
      col_q  <= col_d;
    end
  end
endmodule

// File: rtl/lbm_range.sv
module lbm_range #(
  parameter int ROWS   = 3,
  parameter int COLS   = 4,
  parameter int NIN    = 2,
  parameter int LBACK  = 2,
  parameter int CW     = 3,
  parameter int SW     = 5,
  parameter int GENE_W = 8
) (
  input  logic [CW-1:0]     col,
  output logic [GENE_W-1:0] lo,
  output logic [SW-1:0]     size
);
  logic [GENE_W-1:0] lo_tab [COLS+1];
  logic [SW-1:0]     sz_tab [COLS+1];

  for (genvar c = 0; c <= COLS; c++) begin : g_col
    localparam int HI = c * ROWS + 2 * NIN + 1;
    localparam int LO = (c > LBACK) ? (2 * NIN + 2 + (c - LBACK) * ROWS) : 0;
    assign lo_tab[c] = GENE_W'(LO);
    assign sz_tab[c] = SW'(HI - LO + 1);
  end

  always_comb begin
    lo   = '0;
    size = SW'(1);
    for (int c = 0; c <= COLS; c++) begin
      if (col == CW'(c)) begin
        lo   = lo_tab[c];
        size = sz_tab[c];
      end
    end
  end
endmodule

// File: rtl/lbm_draw.sv
module lbm_draw #(
  parameter int SW     = 5,
  parameter int GENE_W = 8
) (
  input  logic [15:0]       rnd,
  input  logic [GENE_W-1:0] lo,
  input  logic [SW-1:0]     size,
  input  logic              is_func,
  output logic [GENE_W-1:0] value
);
  logic [SW-1:0]    span;
  logic [SW+15:0]   prod;
  logic [SW-1:0]    pick;

  always_comb begin
    span = is_func ? (size + SW'(12)) : size;
    prod = {{SW{1'b0}}, rnd} * {16'd0, span};
    pick = prod[SW+15:16];
    if (is_func && (pick >= size))
      value = GENE_W'(size) - GENE_W'(pick) - GENE_W'(1);
    else
      value = lo + GENE_W'(pick);
  end
endmodule

// File: rtl/lb_gene_mutator.sv
module lb_gene_mutator
  import lbm_pkg::*;
#(
  parameter int ROWS   = 3,
  parameter int COLS   = 4,
  parameter int NIN    = 2,
  parameter int LBACK  = 2,
  parameter int NOUT   = 2,
  parameter int GENE_W = 8,
  parameter int RATE_W = 8,
  localparam int NGENE    = 3 * ROWS * COLS + NOUT,
  localparam int AW       = $clog2(NGENE),
  localparam int MAX_NODE = COLS * ROWS + 2 * NIN + 1,
  localparam int CW       = $clog2(COLS + 1),
  localparam int SW       = $clog2(MAX_NODE + 14)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       seed,
  input  logic [RATE_W-1:0] rate,
  output logic              busy,
  output logic              done,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [GENE_W-1:0] wr_data
);
  logic [31:0]       word;
  logic [AW-1:0]     idx;
  gene_role_e        role;
  logic [CW-1:0]     col;
  logic              last;
  logic [GENE_W-1:0] lo;
  logic [SW-1:0]     size;
  logic [GENE_W-1:0] value;
  logic              hit;
  logic              unused_lo;

  assign unused_lo = ^word[15:0];

  lbm_rng u_rng (
    .clk  (clk),
    .rst_n(rst_n),
    .load (start & ~busy),
    .seed (seed),
    .step (busy),
    .word (word)
  );

  lbm_walker #(
    .ROWS(ROWS), .COLS(COLS), .NGENE(NGENE), .AW(AW), .CW(CW)
  ) u_walk (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .busy (busy),
    .idx  (idx),
    .role (role),
    .col  (col),
    .last (last)
  );

  lbm_range #(
    .ROWS(ROWS), .COLS(COLS), .NIN(NIN), .LBACK(LBACK),
    .CW(CW), .SW(SW), .GENE_W(GENE_W)
  ) u_range (
    .col (col),
    .lo  (lo),
    .size(size)
  );

  lbm_draw #(.SW(SW), .GENE_W(GENE_W)) u_draw (
    .rnd    (word[31:16]),
    .lo     (lo),
    .size   (size),
    .is_func(role == ROLE_FUNC),
    .value  (value)
  );

  logic              wr_en_q, wr_en_d;
  logic              done_q, done_d;
  logic [AW-1:0]     addr_q;
  logic [GENE_W-1:0] data_q;

  always_comb begin
    hit     = busy && (word[RATE_W-1:0] < rate);
    wr_en_d = hit;
    done_d  = busy && last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_q <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      wr_en_q <= wr_en_d;
      done_q  <= done_d;
      if (hit) begin
        addr_q <= idx;
        data_q <= value;
      end
    end
  end

  assign wr_en   = wr_en_q;
  assign done    = done_q;
  assign wr_addr = addr_q;
  assign wr_data = data_q;
endmodule

// File: rtl/lbm_checker.sv
module lbm_checker #(
  parameter int AW       = 6,
  parameter int GENE_W   = 8,
  parameter int RATE_W   = 8,
  parameter int NGENE    = 38,
  parameter int MAX_NODE = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [RATE_W-1:0] rate,
  input logic              busy,
  input logic              done,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic [GENE_W-1:0] wr_data
);
  logic [AW:0] vis_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              vis_q <= '0;
    else if (start && !busy) vis_q <= '0;
    else if (busy)           vis_q <= vis_q + 1'b1;
  end

  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !$past(busy) |-> !wr_en);
  a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  a_r4_rate_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rate == '0) |=> !wr_en);
  a_r5_addr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < NGENE));
  a_r6_value_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($signed(wr_data) >= -12 && $signed(wr_data) <= MAX_NODE));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r10_done_count: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(vis_q) == NGENE));
  a_r11_write_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(busy));
endmodule

bind lb_gene_mutator lbm_checker #(
  .AW(AW), .GENE_W(GENE_W), .RATE_W(RATE_W), .NGENE(NGENE), .MAX_NODE(MAX_NODE)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .rate   (rate),
  .busy   (busy),
  .done   (done),
  .wr_en  (wr_en),
  .wr_addr(wr_addr),
  .wr_data(wr_data)
);

// File: tb/lb_gene_mutator_tb.sv
`timescale 1ns/1ps
module lb_gene_mutator_tb;
  localparam int ROWS = 3, COLS = 4, NIN = 2, LBACK = 2, NOUT = 2;
  localparam int GENE_W = 8, RATE_W = 8;
  localparam int NCELLG = 3 * ROWS * COLS;
  localparam int NGENE  = NCELLG + NOUT;
  localparam int AW     = $clog2(NGENE);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] seed = 32'd0;
  logic [RATE_W-1:0] rate = '0;
  logic busy, done, wr_en;
  logic [AW-1:0] wr_addr;
  logic [GENE_W-1:0] wr_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int writes = 0;
  int dones  = 0;

  always #4 clk = ~clk;

  lb_gene_mutator #(
    .ROWS(ROWS), .COLS(COLS), .NIN(NIN), .LBACK(LBACK), .NOUT(NOUT),
    .GENE_W(GENE_W), .RATE_W(RATE_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .rate(rate),
    .busy(busy), .done(done), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic bit [31:0] xs(input bit [31:0] x);
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic int col_of(input int k);
    if (k >= NCELLG) return COLS;
    return (k / 3) / ROWS;
  endfunction

  function automatic int lo_of(input int c);
    if (c > LBACK) return 2 * NIN + 2 + (c - LBACK) * ROWS;
    return 0;
  endfunction

  function automatic int hi_of(input int c);
    return c * ROWS + 2 * NIN + 1;
  endfunction

  function automatic bit is_func(input int k);
    return (k < NCELLG) && (k % 3 == 2);
  endfunction

  function automatic int ref_value(input int k, input bit [31:0] w);
    int c, lo, sz, span, pick;
    c  = col_of(k);
    lo = lo_of(c);
    sz = hi_of(c) - lo + 1;
    span = is_func(k) ? sz + 12 : sz;
    pick = int'((longint'(w >> 16) * span) >> 16);
    if (is_func(k) && pick >= sz) return -(pick - sz + 1);
    return lo + pick;
  endfunction

  // reference model, advanced on each rising edge
  bit        m_busy, m_done, m_wen;
  bit [31:0] m_state;
  int        m_k, m_addr, m_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_wen = 0; m_state = 1; m_k = 0;
    end else begin
      bit [31:0] w;
      m_wen = 0;
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          m_state = (seed == 0) ? 32'd1 : seed;
          m_k = 0;
          m_busy = 1;
        end
      end else begin
        w = xs(m_state);
        m_state = w;
        if (int'(w[RATE_W-1:0]) < int'(rate)) begin
          m_wen = 1;
          m_addr = m_k;
          m_data = ref_value(m_k, w);
        end
        if (m_k == NGENE - 1) begin
          m_busy = 0;
          m_done = 1;
        end else begin
          m_k++;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      int c, lo, hi;
      check(busy === m_busy, "R2 busy", int'(busy), int'(m_busy));
      check(done === m_done, "R10 done", int'(done), int'(m_done));
      check(wr_en === m_wen, "R4/R11 wr_en", int'(wr_en), int'(m_wen));
      if (done) dones++;
      if (wr_en) begin
        writes++;
        check(int'(wr_addr) == m_addr, "R5 wr_addr", int'(wr_addr), m_addr);
        check(int'($signed(wr_data)) == m_data, "R3/R6 wr_data",
              int'($signed(wr_data)), m_data);
        c  = col_of(int'(wr_addr));
        lo = lo_of(c);
        hi = hi_of(c);
        if (is_func(int'(wr_addr)))
          check(($signed(wr_data) >= lo && $signed(wr_data) <= hi) ||
                ($signed(wr_data) <= -1 && $signed(wr_data) >= -12),
                "R8 function range", int'($signed(wr_data)), lo);
        else if (c == COLS)
          check($signed(wr_data) >= lo && $signed(wr_data) <= hi,
                "R9 output range", int'($signed(wr_data)), lo);
        else if (c > LBACK)
          check($signed(wr_data) >= lo && $signed(wr_data) <= hi,
                "R7 levels-back range", int'($signed(wr_data)), lo);
        else
          check($signed(wr_data) >= 0 && $signed(wr_data) <= hi,
                "R6 source range", int'($signed(wr_data)), hi);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run(input bit [31:0] s, input int r, input int hold);
    writes = 0;
    dones  = 0;
    @(negedge clk);
    seed  = s;
    rate  = RATE_W'(r);
    start = 1'b1;
    repeat (hold) @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (dones != 0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && wr_en === 1'b0, "R1 reset state",
          int'({busy, done, wr_en}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy === 1'b0 && wr_en === 1'b0, "R1 idle after release",
          int'({busy, wr_en}), 0);

    run(32'h1234_5678, 13, 1);
    check(dones == 1, "R10 one done per run", dones, 1);

    run(32'hCAFE_F00D, 0, 1);
    check(writes == 0, "R4 rate zero gives no writes", writes, 0);

    run(32'h0BAD_BEEF, 255, 1);
    check(writes > NGENE / 2, "R4 dense rate writes most genes", writes, NGENE);

    run(32'h0, 200, 1);
    check(dones == 1, "R2 zero seed run completes", dones, 1);

    run(32'h7777_0001, 128, 10);
    check(dones == 1, "R2 start held while busy is ignored", dones, 1);

    run(32'hDEAD_0042, 255, 1);
    check(dones == 1, "R10 done after last output gene", dones, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule